// File: doc/BRIEF.md
# Four-Phase ADD-Only Integer Core

This block is a minimal integer core with no pipeline. Each instruction passes through four clocked phases: fetch, decode, execute and write-back. Only the register-register ADD operation is carried out. The program sits in a small read-only store that is filled at elaboration. The architectural state is a thirty-two entry register file, and each register leaves reset holding a value derived from its own index. Because of that preset, a program can produce checkable sums without any load path.

Inside the core, the decoder pulls the register fields out of the instruction. An execute unit holds the adder and the program-counter logic. The register file commits results at the end of the write phase. Debug outputs expose the program counter, the current phase and the register-file write port, so a bench or a trace unit can follow every commit. At the end of the store, the program counter either wraps to the first word or parks on the last word, as a parameter selects.

Top module: `rvadd_core`

## Requirements
- R1: The phase output steps 0 (fetch), 1 (decode), 2 (execute), 3 (write) and back to 0, moving by one on every rising clock edge. A new fetch starts only after a write phase.
- R2: While reset is high, and on the first cycle after it is released, the phase is 0 and the PC is 0. Register xk leaves reset holding k*RESET_STEP modulo 2^32, with RESET_STEP defaulting to 0x08000001, so x0 holds 0.
- R3: The instruction fields sit at these positions: funct7 [31:25], rs2 [24:20], rs1 [19:15], funct3 [14:12], rd [11:7], opcode [6:0]. A word is an ADD only when opcode = 0110011, funct3 = 000 and funct7 = 0000000.
- R4: For an ADD, the write phase shows the port with enable = 1, address = rd and data = x[rs1] + x[rs2] taken modulo 2^32, with carry dropped. The value is committed at the edge that ends the write phase, and later instructions read it.
- R5: A word that is not an ADD still takes all four phases and still advances the PC. It raises no write enable and leaves every register unchanged.
- R6: An ADD whose rd is 0 raises no write enable, and x0 always reads as zero.
- R7: The PC grows by 4 at the edge that enters the write phase and is constant in every other cycle. The store is indexed by the word address PC[5:2].
- R8: With WRAP_PC = 1 (the default), the PC goes from 4*(MEM_WORDS-1) to 0. With WRAP_PC = 0 it stays on the last word.
- R9: The store holds, for words 0 to 11: 002181B3, 002182B3, 00108033, 001003B3, 40208433, 00508493, 00209533, 01080833, 01EF8FB3, 009484B3, 001080B3, 00518133 (hex).
- R10: The write enable is 0 in the fetch, decode and execute phases.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| dbg_pc | output | 32 | Current program counter |
| dbg_phase | output | 2 | Current phase: 0 fetch, 1 decode, 2 execute, 3 write |
| dbg_wr_en | output | 1 | Register-file write enable |
| dbg_wr_addr | output | 5 | Register-file write address |
| dbg_wr_data | output | 32 | Register-file write data |

## Verification
The program runs twice through the wrapped store, so the second pass adds operands that the first pass wrote. This shows whether commits really land, as opposed to operands being fixed reset values. The pattern set covers:
- plain ADDs;
- an ADD aimed at x0, followed by one that reads x0;
- three near-miss words that differ from ADD in only funct7, opcode or funct3, which tells whether the decoder checks all three fields;
- two sums that overflow 32 bits, which tell modular addition apart from a widened or saturating result.

Every cycle is compared against an arithmetic model of the phase, the PC and the write port.

// File: rtl/rvadd_pkg.sv
package rvadd_pkg;

   typedef enum logic [1:0] {
      PH_FETCH  = 2'd0,
      PH_DECODE = 2'd1,
      PH_EXEC   = 2'd2,
      PH_WRITE  = 2'd3
   } phase_e;

   localparam int unsigned REG_AW = 5;

   localparam logic [6:0] OPC_REGREG = 7'b0110011;
   localparam logic [2:0] F3_ADD     = 3'b000;
   localparam logic [6:0] F7_ADD     = 7'b0000000;

   typedef struct packed {
      logic [REG_AW-1:0] rd;
      logic [REG_AW-1:0] rs1;
      logic [REG_AW-1:0] rs2;
      logic              is_add;
   } dec_t;

   // Preloaded program image; words past the image read as a harmless no-op.
   function automatic logic [31:0] prog_word(input int unsigned idx);
      case (idx)
         0:       return 32'h002181B3;
         1:       return 32'h002182B3;
         2:       return 32'h00108033;
         3:       return 32'h001003B3;
         4:       return 32'h40208433;
         5:       return 32'h00508493;
         6:       return 32'h00209533;
         7:       return 32'h01080833;
         8:       return 32'h01EF8FB3;
         9:       return 32'h009484B3;
         10:      return 32'h001080B3;
         11:      return 32'h00518133;
         default: return 32'h00000013;
      endcase
   endfunction

endpackage

// File: rtl/rvadd_decode.sv
module rvadd_decode
   import rvadd_pkg::*;
(
   input  logic [31:0] instr,
   output dec_t        dec
);

   logic [6:0] opcode;
   logic [2:0] funct3;
   logic [6:0] funct7;

   always_comb begin
      opcode     = instr[6:0];
      funct3     = instr[14:12];
      funct7     = instr[31:25];
      dec.rd     = instr[11:7];
      dec.rs1    = instr[19:15];
      dec.rs2    = instr[24:20];
      dec.is_add = (opcode == OPC_REGREG) && (funct3 == F3_ADD) && (funct7 == F7_ADD);
   end

endmodule

// File: rtl/rvadd_alu.sv
module rvadd_alu #(
   parameter int unsigned XLEN = 32
) (
   input  logic [XLEN-1:0] a,
   input  logic [XLEN-1:0] b,
   output logic [XLEN-1:0] sum
);

   // Carry out of the top bit is dropped: modular addition.
   assign sum = a + b;

endmodule

// File: rtl/rvadd_regfile.sv
module rvadd_regfile #(
   parameter int unsigned     XLEN       = 32,
   parameter int unsigned     NREG       = 32,
   parameter logic [XLEN-1:0] RESET_STEP = 32'h0800_0001
) (
   input  logic                    clk,
   input  logic                    rst,
   input  logic                    we,
   input  logic [$clog2(NREG)-1:0] waddr,
   input  logic [XLEN-1:0]         wdata,
   input  logic [$clog2(NREG)-1:0] raddr_a,
   input  logic [$clog2(NREG)-1:0] raddr_b,
   output logic [XLEN-1:0]         rdata_a,
   output logic [XLEN-1:0]         rdata_b
);

   localparam int unsigned AW = $clog2(NREG);

   if (NREG < 2 || (1 << AW) != NREG) begin : g_bad_nreg
      $error("rvadd_regfile: NREG must be a power of two of at least 2");
   end

   logic [XLEN-1:0] regs [NREG];

   always_ff @(posedge clk) begin
      if (rst) begin
         for (int k = 0; k < NREG; k++) begin
            regs[k] <= XLEN'(k) * RESET_STEP;
         end
      end else if (we && (waddr != '0)) begin
         regs[waddr] <= wdata;
      end
   end

   assign rdata_a = (raddr_a == '0) ? '0 : regs[raddr_a];
   assign rdata_b = (raddr_b == '0) ? '0 : regs[raddr_b];

   assert_x0_write_R6: assert property (@(posedge clk) disable iff (rst)
      we |-> (waddr != '0));

endmodule

// File: rtl/rvadd_exec.sv
module rvadd_exec
   import rvadd_pkg::*;
#(
   parameter int unsigned XLEN      = 32,
   parameter int unsigned MEM_WORDS = 12,
   parameter bit          WRAP_PC   = 1'b1
) (
   input  logic            clk,
   input  logic            rst,
   input  phase_e          phase,
   input  logic [XLEN-1:0] opa,
   input  logic [XLEN-1:0] opb,
   output logic [XLEN-1:0] pc,
   output logic [XLEN-1:0] result
);

   localparam logic [XLEN-1:0] LAST_PC = XLEN'(4 * (MEM_WORDS - 1));
   localparam logic [XLEN-1:0] PC_STEP = XLEN'(4);

   logic [XLEN-1:0] sum;
   logic [XLEN-1:0] pc_q;
   logic [XLEN-1:0] pc_next;
   logic [XLEN-1:0] result_q;

   rvadd_alu #(.XLEN(XLEN)) alu_i (
      .a   (opa),
      .b   (opb),
      .sum (sum)
   );

   if (WRAP_PC) begin : g_wrap
      assign pc_next = (pc_q == LAST_PC) ? '0 : pc_q + PC_STEP;
   end else begin : g_hold
      assign pc_next = (pc_q == LAST_PC) ? pc_q : pc_q + PC_STEP;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         pc_q     <= '0;
         result_q <= '0;
      end else if (phase == PH_EXEC) begin
         pc_q     <= pc_next;
         result_q <= sum;
      end
   end

   assign pc     = pc_q;
   assign result = result_q;

   assert_pc_hold_R7: assert property (@(posedge clk) disable iff (rst)
      (phase != PH_EXEC) |=> $stable(pc_q));

   assert_pc_range_R8: assert property (@(posedge clk) disable iff (rst)
      (pc_q <= LAST_PC) && (pc_q[1:0] == 2'b00));

endmodule

// File: rtl/rvadd_core.sv
module rvadd_core
   import rvadd_pkg::*;
#(
   parameter int unsigned     XLEN       = 32,
   parameter int unsigned     MEM_WORDS  = 12,
   parameter bit              WRAP_PC    = 1'b1,
   parameter logic [XLEN-1:0] RESET_STEP = 32'h0800_0001
) (
   input  logic              clk,
   input  logic              rst,
   output logic [XLEN-1:0]   dbg_pc,
   output logic [1:0]        dbg_phase,
   output logic              dbg_wr_en,
   output logic [REG_AW-1:0] dbg_wr_addr,
   output logic [XLEN-1:0]   dbg_wr_data
);

   localparam int unsigned NREG  = 1 << REG_AW;
   localparam int unsigned IDX_W = $clog2(MEM_WORDS);

   if (XLEN != 32) begin : g_bad_xlen
      $error("rvadd_core: the instruction format fixes XLEN at 32");
   end
   if (MEM_WORDS < 2 || MEM_WORDS > 64) begin : g_bad_mem
      $error("rvadd_core: MEM_WORDS must lie in 2..64");
   end

   // Instruction store, filled at elaboration.
   logic [31:0] rom [MEM_WORDS];
   for (genvar i = 0; i < MEM_WORDS; i++) begin : g_rom
      assign rom[i] = prog_word(i);
   end

   phase_e          phase_q;
   logic [31:0]     ir_q;
   dec_t            dec_w;
   dec_t            dec_q;
   logic [XLEN-1:0] opa_q;
   logic [XLEN-1:0] opb_q;
   logic [XLEN-1:0] rd_a;
   logic [XLEN-1:0] rd_b;
   logic [XLEN-1:0] pc;
   logic [XLEN-1:0] result;
   logic [IDX_W-1:0] pc_idx;
   logic [31:0]     fetch_word;
   logic            wr_en;

   assign pc_idx     = pc[IDX_W+1:2];
   assign fetch_word = (32'(pc_idx) < MEM_WORDS) ? rom[pc_idx] : 32'h0000_0013;

   always_ff @(posedge clk) begin
      if (rst) phase_q <= PH_FETCH;
      else     phase_q <= phase_e'(phase_q + 2'd1);
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         ir_q  <= 32'h0000_0013;
         dec_q <= '0;
         opa_q <= '0;
         opb_q <= '0;
      end else begin
         if (phase_q == PH_FETCH) ir_q <= fetch_word;
         if (phase_q == PH_DECODE) begin
            dec_q <= dec_w;
            opa_q <= rd_a;
            opb_q <= rd_b;
         end
      end
   end

   rvadd_decode dec_i (
      .instr (ir_q),
      .dec   (dec_w)
   );

   rvadd_exec #(
      .XLEN      (XLEN),
      .MEM_WORDS (MEM_WORDS),
      .WRAP_PC   (WRAP_PC)
   ) exec_i (
      .clk    (clk),
      .rst    (rst),
      .phase  (phase_q),
      .opa    (opa_q),
      .opb    (opb_q),
      .pc     (pc),
      .result (result)
   );

   assign wr_en = (phase_q == PH_WRITE) && dec_q.is_add && (dec_q.rd != '0);

   rvadd_regfile #(
      .XLEN       (XLEN),
      .NREG       (NREG),
      .RESET_STEP (RESET_STEP)
   ) rf_i (
      .clk     (clk),
      .rst     (rst),
      .we      (wr_en),
      .waddr   (dec_q.rd),
      .wdata   (result),
      .raddr_a (dec_w.rs1),
      .raddr_b (dec_w.rs2),
      .rdata_a (rd_a),
      .rdata_b (rd_b)
   );

   assign dbg_pc      = pc;
   assign dbg_phase   = phase_q;
   assign dbg_wr_en   = wr_en;
   assign dbg_wr_addr = dec_q.rd;
   assign dbg_wr_data = result;

   assert_phase_order_R1: assert property (@(posedge clk) disable iff (rst)
      !$past(rst) |-> (phase_q == phase_e'($past(phase_q) + 2'd1)));

   assert_fetch_after_write_R1: assert property (@(posedge clk) disable iff (rst)
      (phase_q == PH_FETCH && !$past(rst)) |-> ($past(phase_q) == PH_WRITE));

   assert_pc_moves_in_write_R7: assert property (@(posedge clk) disable iff (rst)
      (phase_q == PH_WRITE && !$past(rst)) |-> ($past(pc) != pc || (!WRAP_PC && pc == XLEN'(4 * (MEM_WORDS - 1)))));

endmodule

// File: tb/rvadd_core_tb_top.sv
`timescale 1ns/1ps
module rvadd_core_tb_top;

   localparam int          NWORDS = 12;
   localparam logic [31:0] STEP   = 32'h0800_0001;
   localparam int          PASSES = 2;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [31:0] dbg_pc;
   logic [1:0]  dbg_phase;
   logic        dbg_wr_en;
   logic [4:0]  dbg_wr_addr;
   logic [31:0] dbg_wr_data;

   int total = 0;
   int fails = 0;

   logic [31:0] model [32];
   logic [6:0]  t_f7  [NWORDS];
   logic [4:0]  t_rs2 [NWORDS];
   logic [4:0]  t_rs1 [NWORDS];
   logic [2:0]  t_f3  [NWORDS];
   logic [4:0]  t_rd  [NWORDS];
   logic [6:0]  t_op  [NWORDS];
   logic [31:0] t_hex [NWORDS];

   always #4 clk = ~clk;

   rvadd_core dut_i (
      .clk         (clk),
      .rst         (rst),
      .dbg_pc      (dbg_pc),
      .dbg_phase   (dbg_phase),
      .dbg_wr_en   (dbg_wr_en),
      .dbg_wr_addr (dbg_wr_addr),
      .dbg_wr_data (dbg_wr_data)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic setw(input int i, input logic [6:0] f7, input logic [4:0] rs2,
                       input logic [4:0] rs1, input logic [2:0] f3,
                       input logic [4:0] rd, input logic [6:0] op,
                       input logic [31:0] hex);
      t_f7[i] = f7; t_rs2[i] = rs2; t_rs1[i] = rs1;
      t_f3[i] = f3; t_rd[i]  = rd;  t_op[i]  = op; t_hex[i] = hex;
   endtask

   initial begin
      // R9 program listing, described by fields plus the listed hex word.
      setw(0,  7'h00, 5'd2,  5'd3,  3'd0, 5'd3,  7'h33, 32'h002181B3);
      setw(1,  7'h00, 5'd2,  5'd3,  3'd0, 5'd5,  7'h33, 32'h002182B3);
      setw(2,  7'h00, 5'd1,  5'd1,  3'd0, 5'd0,  7'h33, 32'h00108033);
      setw(3,  7'h00, 5'd1,  5'd0,  3'd0, 5'd7,  7'h33, 32'h001003B3);
      setw(4,  7'h20, 5'd2,  5'd1,  3'd0, 5'd8,  7'h33, 32'h40208433);
      setw(5,  7'h00, 5'd5,  5'd1,  3'd0, 5'd9,  7'h13, 32'h00508493);
      setw(6,  7'h00, 5'd2,  5'd1,  3'd1, 5'd10, 7'h33, 32'h00209533);
      setw(7,  7'h00, 5'd16, 5'd16, 3'd0, 5'd16, 7'h33, 32'h01080833);
      setw(8,  7'h00, 5'd30, 5'd31, 3'd0, 5'd31, 7'h33, 32'h01EF8FB3);
      setw(9,  7'h00, 5'd9,  5'd9,  3'd0, 5'd9,  7'h33, 32'h009484B3);
      setw(10, 7'h00, 5'd1,  5'd1,  3'd0, 5'd1,  7'h33, 32'h001080B3);
      setw(11, 7'h00, 5'd5,  5'd3,  3'd0, 5'd2,  7'h33, 32'h00518133);
      for (int k = 0; k < 32; k++) model[k] = 32'(k) * STEP;

      for (int i = 0; i < NWORDS; i++) begin
         chk({t_f7[i], t_rs2[i], t_rs1[i], t_f3[i], t_rd[i], t_op[i]} == t_hex[i],
             "R3", "field layout of listed word",
             {t_f7[i], t_rs2[i], t_rs1[i], t_f3[i], t_rd[i], t_op[i]}, t_hex[i]);
      end

      repeat (3) @(posedge clk);
      @(negedge clk);
      chk(dbg_phase == 2'd0, "R2", "phase in reset", 32'(dbg_phase), 32'd0);
      chk(dbg_pc == 32'd0, "R2", "pc in reset", dbg_pc, 32'd0);
      chk(dbg_wr_en == 1'b0, "R10", "wr_en in reset", 32'(dbg_wr_en), 32'd0);
      rst = 1'b0;

      for (int cyc = 0; cyc < 4 * NWORDS * PASSES; cyc++) begin
         int          ph;
         int          idx;
         bit          is_add;
         logic [31:0] exp_pc;
         logic [31:0] exp_sum;
         ph     = cyc % 4;
         idx    = (cyc / 4) % NWORDS;
         is_add = (t_op[idx] == 7'b0110011) && (t_f3[idx] == 3'b000) && (t_f7[idx] == 7'b0000000);
         exp_pc = (ph == 3) ? 32'(4 * ((idx + 1) % NWORDS)) : 32'(4 * idx);

         chk(dbg_phase == 2'(ph), "R1", "phase sequence", 32'(dbg_phase), 32'(ph));
         chk(dbg_pc == exp_pc, (ph == 3 && idx == NWORDS - 1) ? "R8" : "R7",
             "pc value", dbg_pc, exp_pc);

         if (ph != 3) begin
            chk(dbg_wr_en == 1'b0, "R10", "wr_en outside write", 32'(dbg_wr_en), 32'd0);
         end else if (!is_add) begin
            chk(dbg_wr_en == 1'b0, "R5", "non-ADD word writes", 32'(dbg_wr_en), 32'd0);
         end else if (t_rd[idx] == 5'd0) begin
            chk(dbg_wr_en == 1'b0, "R6", "write to x0", 32'(dbg_wr_en), 32'd0);
         end else begin
            exp_sum = model[t_rs1[idx]] + model[t_rs2[idx]];
            chk(dbg_wr_en == 1'b1, "R4", "ADD wr_en", 32'(dbg_wr_en), 32'd1);
            chk(dbg_wr_addr == t_rd[idx], "R4", "ADD wr_addr", 32'(dbg_wr_addr), 32'(t_rd[idx]));
            chk(dbg_wr_data == exp_sum, "R4", "ADD sum mod 2^32", dbg_wr_data, exp_sum);
            model[t_rd[idx]] = exp_sum;
         end
         @(posedge clk);
         @(negedge clk);
      end

      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      total++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
   end

endmodule